// File: doc/BRIEF.md
# SMM-Aware Memory Address Router

This block sits in the memory-request path of a host bridge and decides, for every request, where it is sent. A request carries a 36-bit address, a read/write bit, the interface it arrived on (processor bus, hub link or graphics port) and a flag marking system-management code fetches or data accesses. The router compares the address against a programmable protected region just below the top of low memory, against a fixed high alias of the legacy system-management area, and against two fixed windows used for interrupt controllers and interrupt messages. It then returns a destination, an address that may have been rewritten, and a flag telling the requester that the access was nullified.

The protected regions open only when the right combination of configuration enables is set and the request comes from the processor with system-management permission. Permission means either the open bit or a system-management code request. Requests from the hub link or graphics port are always kept out of these regions: a read returns the contents of address 0 and a write is dropped. Processor requests without permission are terminated without the nullify flag. The decision is registered and appears one clock after the request.

Top module: `smm_addr_router`

## Requirements
- R1: `rsp_valid` is low in reset and in every cycle follows `req_valid` of the previous cycle. The fields of an accepted request appear on the outputs one clock after it. Reset clears all outputs to zero.
- R2: The protected low window covers `[cfg_tolm - S, cfg_tolm)`, where S is 128 KB for `cfg_tseg_size`=0, 256 KB for 1, 512 KB for 2 and 1 MB for 3.
- R3: A processor request (origin 0) in the protected low window is treated as permitted when `cfg_smram_en` and `cfg_tseg_en` are set and either `cfg_open` or `req_smm_code` is set. A permitted request goes to memory (dest 0) with its address unchanged and the nullify flag low.
- R4: A processor request that is not permitted and falls in an active protected window gets dest 3 (terminate), its address unchanged and the nullify flag low.
- R5: A request from the hub link (origin 1) or the graphics port (origin 2, or 3 which is treated as non-processor) that falls in an active protected window gets dest 3 with the nullify flag high. This holds whatever the state of `cfg_open` and `req_smm_code`.
- R6: With `cfg_smram_en` or `cfg_tseg_en` clear, requests in the low protected range from every origin go to memory with the address unchanged.
- R7: The high alias 0xFEDA0000–0xFEDBFFFF is active when `cfg_smram_en` and `cfg_hsmram_en` are both set. Permitted processor requests in the active alias go to memory with address 0xA0000 plus the low 17 bits of the request address. Other requests in the active alias follow R4 or R5. When the alias is inactive, requests in it go to memory with the address unchanged.
- R8: Processor requests in 0xFEC00000–0xFEC7FFFF go to the hub link (dest 1) with the address unchanged, whatever the configuration. Other origins in this window fall through to the lower-priority rules.
- R9: Graphics-port writes in 0xFEE00000–0xFEEFFFFF go to the interrupt-message path (dest 2). All other requests in that window fall through to the lower-priority rules.
- R10: Where windows overlap, the priority order is interrupt window, then IOAPIC window, then high alias, then protected low window. Requests that match no rule go to memory with the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_origin | input | 2 | 0 processor bus, 1 hub link, 2 graphics port, 3 reserved (non-processor) |
| req_smm_code | input | 1 | Request is a system-management access from the processor |
| cfg_tolm | input | ADDR_W | Top of low memory (exclusive) |
| cfg_tseg_size | input | 2 | Protected low window size code |
| cfg_smram_en | input | 1 | Global system-management memory enable |
| cfg_open | input | 1 | System-management memory open to all processor accesses |
| cfg_tseg_en | input | 1 | Protected low window enable |
| cfg_hsmram_en | input | 1 | High alias enable |
| rsp_valid | output | 1 | Decision valid |
| rsp_dest | output | 2 | 0 memory, 1 hub link, 2 interrupt message, 3 terminate |
| rsp_addr | output | ADDR_W | Address after remap |
| rsp_nullify | output | 1 | Read returns address-0 data, write is dropped |

## Verification
The bench builds the router with its default parameters: 36-bit addresses, 128 KB granule and the fixed window bounds. It sweeps every size code, every combination of the four enables, all origins, read and write, and both permission states, against an address set placed on each window edge. It does this for two values of top of low memory. One value is low in memory. The other is 0xFEC40000, where a 1 MB protected window overlaps the IOAPIC window, so the priority rules and the fall-through of non-processor requests can be observed.

// File: rtl/smm_route_pkg.sv
package smm_route_pkg;

   typedef enum logic [1:0] {
      ORG_CPU = 2'd0,
      ORG_HUB = 2'd1,
      ORG_GFX = 2'd2,
      ORG_RSV = 2'd3
   } origin_e;

   typedef enum logic [1:0] {
      DST_MEM  = 2'd0,
      DST_HUB  = 2'd1,
      DST_IRQ  = 2'd2,
      DST_TERM = 2'd3
   } dest_e;

   localparam int unsigned NUM_FIXED_WIN = 3;
   localparam int unsigned WIN_IRQ  = 0;
   localparam int unsigned WIN_IO   = 1;
   localparam int unsigned WIN_HSMM = 2;

endpackage

// File: rtl/smm_range_hit.sv
module smm_range_hit #(
   parameter int unsigned        AW = 36,
   parameter logic [AW-1:0]      LO = '0,
   parameter logic [AW-1:0]      HI = '1
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   if (LO > HI) begin : g_bad_range
      $error("smm_range_hit: LO above HI");
   end

   assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/smm_tseg_window.sv
module smm_tseg_window #(
   parameter int unsigned AW        = 36,
   parameter int unsigned GRAN_LOG2 = 17,
   parameter int unsigned SIZE_W    = 2
) (
   input  logic [AW-1:0]     tolm,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [AW-1:0]     addr,
   output logic              hit
);
   localparam int unsigned MAX_LOG2 = GRAN_LOG2 + (1 << SIZE_W) - 1;

   if (MAX_LOG2 >= AW) begin : g_bad_span
      $error("smm_tseg_window: largest window does not fit the address width");
   end

   logic [AW-1:0] span;
   logic [AW-1:0] base;

   always_comb begin
      span = {{(AW-1){1'b0}}, 1'b1} << (GRAN_LOG2 + 32'(size_code));
      base = tolm - span;
      hit  = (addr >= base) && (addr < tolm);
   end
endmodule

// File: rtl/smm_route_decide.sv
module smm_route_decide
   import smm_route_pkg::*;
#(
   parameter int unsigned   AW         = 36,
   parameter int unsigned   REMAP_KEEP = 17,
   parameter logic [AW-1:0] REMAP_BASE = 'h000A_0000
) (
   input  logic [AW-1:0] addr,
   input  logic          write,
   input  origin_e       origin,
   input  logic          smm_code,
   input  logic          hit_irq,
   input  logic          hit_io,
   input  logic          hit_hsmm,
   input  logic          hit_tseg,
   input  logic          smram_en,
   input  logic          open_en,
   input  logic          tseg_en,
   input  logic          hsmram_en,
   output dest_e         dest,
   output logic [AW-1:0] addr_out,
   output logic          nullify
);
   localparam logic [AW-1:0] KEEP_MASK = {{(AW-REMAP_KEEP){1'b0}}, {REMAP_KEEP{1'b1}}};

   if ((REMAP_BASE & KEEP_MASK) != '0) begin : g_bad_base
      $error("smm_route_decide: remap base not aligned to kept bits");
   end

   logic is_cpu;
   logic permitted;
   logic hsmm_live;
   logic tseg_live;

   always_comb begin
      is_cpu    = (origin == ORG_CPU);
      permitted = is_cpu && smram_en && (open_en || smm_code);
      hsmm_live = hit_hsmm && smram_en && hsmram_en;
      tseg_live = hit_tseg && smram_en && tseg_en;

      dest     = DST_MEM;
      addr_out = addr;
      nullify  = 1'b0;

      if (hit_irq && (origin == ORG_GFX) && write) begin
         dest = DST_IRQ;
      end else if (hit_io && is_cpu) begin
         dest = DST_HUB;
      end else if (hsmm_live || tseg_live) begin
         if (permitted) begin
            dest = DST_MEM;
            if (hsmm_live) begin
               addr_out = REMAP_BASE | (addr & KEEP_MASK);
            end
         end else begin
            dest    = DST_TERM;
            nullify = !is_cpu;
         end
      end
   end
endmodule

// File: rtl/smm_addr_router.sv
module smm_addr_router
   import smm_route_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 36,
   parameter int unsigned       TSEG_GRAN  = 17,
   parameter int unsigned       SIZE_W     = 2,
   parameter int unsigned       REMAP_KEEP = 17,
   parameter logic [ADDR_W-1:0] REMAP_BASE = 'h000A_0000,
   parameter logic [ADDR_W-1:0] IRQ_LO     = 'hFEE0_0000,
   parameter logic [ADDR_W-1:0] IRQ_HI     = 'hFEEF_FFFF,
   parameter logic [ADDR_W-1:0] IO_LO      = 'hFEC0_0000,
   parameter logic [ADDR_W-1:0] IO_HI      = 'hFEC7_FFFF,
   parameter logic [ADDR_W-1:0] HSMM_LO    = 'hFEDA_0000,
   parameter logic [ADDR_W-1:0] HSMM_HI    = 'hFEDB_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [1:0]        req_origin,
   input  logic              req_smm_code,
   input  logic [ADDR_W-1:0] cfg_tolm,
   input  logic [SIZE_W-1:0] cfg_tseg_size,
   input  logic              cfg_smram_en,
   input  logic              cfg_open,
   input  logic              cfg_tseg_en,
   input  logic              cfg_hsmram_en,
   output logic              rsp_valid,
   output logic [1:0]        rsp_dest,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_nullify
);
   localparam logic [ADDR_W-1:0] WIN_LO [NUM_FIXED_WIN] = '{IRQ_LO, IO_LO, HSMM_LO};
   localparam logic [ADDR_W-1:0] WIN_HI [NUM_FIXED_WIN] = '{IRQ_HI, IO_HI, HSMM_HI};

   if (ADDR_W < 33) begin : g_bad_aw
      $error("smm_addr_router: address width must reach the 4 GB windows");
   end
   if (REMAP_KEEP >= ADDR_W) begin : g_bad_keep
      $error("smm_addr_router: remap keeps every address bit");
   end
   if ((HSMM_HI - HSMM_LO + 1) != ({{(ADDR_W-1){1'b0}}, 1'b1} << REMAP_KEEP)) begin : g_bad_alias
      $error("smm_addr_router: alias window size differs from remapped span");
   end

   logic [NUM_FIXED_WIN-1:0] win_hit;
   logic                     tseg_hit;
   dest_e                    nxt_dest;
   logic [ADDR_W-1:0]        nxt_addr;
   logic                     nxt_null;

   for (genvar w = 0; w < NUM_FIXED_WIN; w++) begin : g_win
      smm_range_hit #(
         .AW (ADDR_W),
         .LO (WIN_LO[w]),
         .HI (WIN_HI[w])
      ) u_hit (
         .addr (req_addr),
         .hit  (win_hit[w])
      );
   end

   smm_tseg_window #(
      .AW        (ADDR_W),
      .GRAN_LOG2 (TSEG_GRAN),
      .SIZE_W    (SIZE_W)
   ) u_tseg (
      .tolm      (cfg_tolm),
      .size_code (cfg_tseg_size),
      .addr      (req_addr),
      .hit       (tseg_hit)
   );

   smm_route_decide #(
      .AW         (ADDR_W),
      .REMAP_KEEP (REMAP_KEEP),
      .REMAP_BASE (REMAP_BASE)
   ) u_decide (
      .addr      (req_addr),
      .write     (req_write),
      .origin    (origin_e'(req_origin)),
      .smm_code  (req_smm_code),
      .hit_irq   (win_hit[WIN_IRQ]),
      .hit_io    (win_hit[WIN_IO]),
      .hit_hsmm  (win_hit[WIN_HSMM]),
      .hit_tseg  (tseg_hit),
      .smram_en  (cfg_smram_en),
      .open_en   (cfg_open),
      .tseg_en   (cfg_tseg_en),
      .hsmram_en (cfg_hsmram_en),
      .dest      (nxt_dest),
      .addr_out  (nxt_addr),
      .nullify   (nxt_null)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_dest    <= DST_MEM;
         rsp_addr    <= '0;
         rsp_nullify <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_dest    <= nxt_dest;
            rsp_addr    <= nxt_addr;
            rsp_nullify <= nxt_null;
         end
      end
   end

   // R1: one-cycle registered handshake
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rsp_valid == $past(req_valid));

   // R4: processor requests are never nullified
   a_r4_cpu_no_null: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_origin == ORG_CPU) |=> !rsp_nullify);

   // R5: nullified requests are always terminated
   a_r5_null_is_term: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_nullify |-> rsp_dest == DST_TERM);

   // R8: processor IOAPIC accesses go to the hub link
   a_r8_ioapic_hub: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_origin == ORG_CPU) && (req_addr >= IO_LO) && (req_addr <= IO_HI)
      |=> rsp_dest == DST_HUB);

   // R9: interrupt-message path only for graphics writes
   a_r9_irq_gfx_write: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_dest == DST_IRQ) |-> $past(req_write) && ($past(req_origin) == ORG_GFX));

   // R7: a rewritten address only ever goes to memory
   a_r7_remap_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_addr != $past(req_addr)) |-> rsp_dest == DST_MEM);
endmodule

// File: tb/sim_smm_addr_router.sv
module sim_smm_addr_router;
   localparam int AW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [1:0]    req_origin = 2'd0;
   logic          req_smm_code = 1'b0;
   logic [AW-1:0] cfg_tolm = '0;
   logic [1:0]    cfg_tseg_size = 2'd0;
   logic          cfg_smram_en = 1'b0;
   logic          cfg_open = 1'b0;
   logic          cfg_tseg_en = 1'b0;
   logic          cfg_hsmram_en = 1'b0;
   logic          rsp_valid;
   logic [1:0]    rsp_dest;
   logic [AW-1:0] rsp_addr;
   logic          rsp_nullify;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   smm_addr_router u0 (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
      .req_write (req_write), .req_origin (req_origin), .req_smm_code (req_smm_code),
      .cfg_tolm (cfg_tolm), .cfg_tseg_size (cfg_tseg_size), .cfg_smram_en (cfg_smram_en),
      .cfg_open (cfg_open), .cfg_tseg_en (cfg_tseg_en), .cfg_hsmram_en (cfg_hsmram_en),
      .rsp_valid (rsp_valid), .rsp_dest (rsp_dest), .rsp_addr (rsp_addr),
      .rsp_nullify (rsp_nullify)
   );

   task automatic check(input string req, input logic [AW+3:0] act, input logic [AW+3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (addr=%h org=%0d wr=%0b smm=%0b)",
                  req, act, exp, req_addr, req_origin, req_write, req_smm_code);
      end
   endtask

   // Reference model written from the requirement list
   task automatic model(input logic [AW-1:0] a, output logic [1:0] d,
                        output logic [AW-1:0] ao, output logic nl, output string tag);
      logic [AW-1:0] sz;
      bool_t_dummy: begin end
      sz = 36'h2_0000 * (36'd1 << cfg_tseg_size);
      d = 2'd0; ao = a; nl = 1'b0; tag = "R10";
      if (a >= 36'hFEE0_0000 && a <= 36'hFEEF_FFFF && req_origin == 2'd2 && req_write) begin
         d = 2'd2; tag = "R9";
      end else if (a >= 36'hFEC0_0000 && a <= 36'hFEC7_FFFF && req_origin == 2'd0) begin
         d = 2'd1; tag = "R8";
      end else if (a >= 36'hFEDA_0000 && a <= 36'hFEDB_FFFF && cfg_smram_en && cfg_hsmram_en) begin
         if (req_origin == 2'd0 && (cfg_open || req_smm_code)) begin
            ao = 36'hA_0000 + (a % 36'h2_0000); tag = "R7";
         end else begin
            d = 2'd3; nl = (req_origin != 2'd0); tag = nl ? "R5" : "R4";
         end
      end else if (a < cfg_tolm && a >= cfg_tolm - sz) begin
         if (!(cfg_smram_en && cfg_tseg_en)) tag = "R6";
         else if (req_origin == 2'd0 && (cfg_open || req_smm_code)) tag = "R3";
         else begin
            d = 2'd3; nl = (req_origin != 2'd0); tag = nl ? "R5" : "R4";
         end
         tag = {tag, "/R2"};
      end else if (a >= 36'hFEDA_0000 && a <= 36'hFEDB_FFFF) begin
         tag = "R7";
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [AW-1:0] tolms [2];
      logic [AW-1:0] pts [21];
      logic [1:0]    ed;
      logic [AW-1:0] ea;
      logic          en;
      string         tag;
      logic [AW-1:0] base;
      tolms[0] = 36'h0_0800_0000;
      tolms[1] = 36'h0_FEC4_0000;

      repeat (3) @(negedge clk);
      check("R1 reset", {rsp_valid, rsp_dest, rsp_addr, rsp_nullify}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle", {3'b0, rsp_valid}, 4'd0);

      for (int t = 0; t < 2; t++) begin
         cfg_tolm = tolms[t];
         for (int s = 0; s < 4; s++) begin
            cfg_tseg_size = 2'(s);
            base = cfg_tolm - 36'h2_0000 * (36'd1 << s);
            pts = '{base - 1, base, base + 36'h1000, cfg_tolm - 1, cfg_tolm,
                    36'h0, 36'hA_0000, 36'hFEBF_FFFF, 36'hFEC0_0000, 36'hFEC7_FFFF,
                    36'hFEC8_0000, 36'hFED9_FFFF, 36'hFEDA_0000, 36'hFEDA_1234,
                    36'hFEDB_FFFF, 36'hFEDC_0000, 36'hFEDF_FFFF, 36'hFEE0_0000,
                    36'hFEEF_FFFF, 36'hFEF0_0000, 36'h1_FEE0_0000};
            for (int c = 0; c < 16; c++) begin
               {cfg_smram_en, cfg_open, cfg_tseg_en, cfg_hsmram_en} = 4'(c);
               for (int o = 0; o < 3; o++) begin
                  for (int w = 0; w < 2; w++) begin
                     for (int m = 0; m < 2; m++) begin
                        for (int p = 0; p < 21; p++) begin
                           req_valid = 1'b1;
                           req_origin = 2'(o);
                           req_write = w[0];
                           req_smm_code = m[0];
                           req_addr = pts[p];
                           model(pts[p], ed, ea, en, tag);
                           @(negedge clk);
                           check({tag, " R1"}, {rsp_valid, rsp_dest, rsp_addr, rsp_nullify},
                                 {1'b1, ed, ea, en});
                        end
                     end
                  end
               end
            end
         end
      end

      // reserved origin treated as non-processor
      cfg_tolm = tolms[0]; cfg_tseg_size = 2'd0;
      {cfg_smram_en, cfg_open, cfg_tseg_en, cfg_hsmram_en} = 4'b1111;
      req_origin = 2'd3; req_addr = 36'hFEDA_0040; req_write = 1'b0; req_smm_code = 1'b1;
      @(negedge clk);
      check("R5 reserved origin", {rsp_valid, rsp_dest, rsp_addr, rsp_nullify},
            {1'b1, 2'd3, 36'hFEDA_0040, 1'b1});
      req_valid = 1'b0;
      @(negedge clk);
      check("R1 valid drops", {3'b0, rsp_valid}, 4'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule